// File: doc/BRIEF.md
# Three-Phase Inverter Overcurrent Trip Controller

This block sits between three complementary PWM generators and the six gate-drive outputs of a three-phase motor inverter. It takes three active-low overcurrent comparator signals, one for each phase current (U, V, W). Each output has its own trip path with its own comparator selection, event class, asynchronous override enable and safe-level action. A qualifying fault latches a trip that replaces the PWM level on that output with the configured safe level.

There are two event classes. A one-shot trip stays latched until software pulses the clear strobe. A cycle-by-cycle trip releases itself at the next PWM period start once the fault has gone. An asynchronous option forces an output to its safe level straight from the raw comparator signal, with no clock edge in the path. A global option makes a fault on any one phase trip all six outputs together. Sticky per-phase status flags and a single-cycle interrupt pulse report trips.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: Fault inputs are active low: bit 0 is U, bit 1 is V and bit 2 is W. A path's 2-bit select code picks which input drives it: 0 = U, 1 = V, 2 = W, 3 = none (the path never fires).
- R2: On the synchronous path, a fault that goes low before rising edge k forces the affected outputs right after edge k+2. Two synchronizer flops come first, then the trip latch. Outputs are unchanged after edges k and k+1.
- R3: A one-shot trip stays latched after its fault goes away. It clears on a clear-strobe edge only if the synchronized fault is absent. If the fault is still present, the latch stays set.
- R4: A cycle-by-cycle trip holds until a period-start pulse. At that edge it clears if the synchronized fault is gone and stays set if the fault is still present.
- R5: The 2-bit action code of a tripped output behaves as follows. 00 drives it low and raises its high-impedance flag. 01 drives it high. 10 drives it low. 11 leaves the PWM input through unchanged.
- R6: With the asynchronous enable set, a low on the selected raw fault input forces that output combinationally, without waiting for a clock edge. A fault pulse that no clock edge samples leaves no latched trip behind.
- R7: With the global option set, a fault on any phase fires every one of the six paths, whatever their select codes.
- R8: The per-phase sticky flags record a one-shot or a cycle-by-cycle trip on either output of that phase. The clear strobe clears them, but a trip that is still latching wins over the clear.
- R9: The interrupt is a single-cycle pulse. It is raised at the same edge at which any trip latch goes from clear to set.
- R10: An output that is not tripped follows its PWM input, and its high-impedance flag is low.
- R11: A path's class bit selects the event type: 0 = one-shot, 1 = cycle-by-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_n | input | 3 | Active-low overcurrent comparators, U/V/W |
| period_start | input | 1 | PWM period-start pulse |
| clr_trip | input | 1 | Clear strobe for one-shot latches and sticky flags |
| cfg_global | input | 1 | Any phase fault trips all outputs |
| cfg_src_a | input | 6 | Per-phase source select for A paths, 2 bits each |
| cfg_src_b | input | 6 | Per-phase source select for B paths, 2 bits each |
| cfg_cls_a | input | 3 | Per-phase event class for A paths |
| cfg_cls_b | input | 3 | Per-phase event class for B paths |
| cfg_async_a | input | 3 | Per-phase asynchronous override for A paths |
| cfg_async_b | input | 3 | Per-phase asynchronous override for B paths |
| cfg_act_a | input | 6 | Per-phase action code for A outputs, 2 bits each |
| cfg_act_b | input | 6 | Per-phase action code for B outputs, 2 bits each |
| pwm_a_in | input | 3 | PWM A levels from the generators |
| pwm_b_in | input | 3 | PWM B levels from the generators |
| pwm_a_out | output | 3 | Gate-drive A levels |
| pwm_b_out | output | 3 | Gate-drive B levels |
| hiz_a | output | 3 | High-impedance indication for A outputs |
| hiz_b | output | 3 | High-impedance indication for B outputs |
| sts_ost | output | 3 | Sticky one-shot trip flags per phase |
| sts_cbc | output | 3 | Sticky cycle-by-cycle trip flags per phase |
| trip_irq | output | 1 | Single-cycle trip interrupt |

## Verification
The bench counts edges after a fault falls. A design with one synchronizer flop too few or too many trips an edge early or late. It clears a one-shot trip while the fault is still low, which a design that gives the clear priority over a fresh set gets wrong. It exercises cycle-by-cycle release with the fault both present and absent at the period start, to catch a latch that drops unconditionally or ignores the period pulse. It crosses the select codes with a phase fault, including code 3 and a source taken from another phase, and under the global option, so that a design that wires each path to its own phase shows up. A sub-cycle glitch with the asynchronous enable set must move the output at once and leave no latch, which separates the raw path from the synchronized one.

// File: rtl/trip_pkg.sv
package trip_pkg;

    localparam int N_PH  = 3;
    localparam int SEL_W = 2;
    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_NONE = 2'b11
    } trip_act_e;

    typedef enum logic {
        CLS_OST = 1'b0,
        CLS_CBC = 1'b1
    } trip_cls_e;

    typedef struct packed {
        logic lvl;
        logic hiz;
    } drive_t;

    // Event of one path: selected active-low comparator, or any phase in global mode
    function automatic logic path_event(input logic [N_PH-1:0] flt_n,
                                        input logic [SEL_W-1:0] sel,
                                        input logic glob);
        logic hit;
        hit = 1'b0;
        if (glob)
            hit = ~&flt_n;
        else if (int'(sel) < N_PH)
            hit = ~flt_n[sel];
        return hit;
    endfunction

    function automatic drive_t apply_act(input trip_act_e act,
                                         input logic pwm,
                                         input logic tripped);
        drive_t d;
        d.lvl = pwm;
        d.hiz = 1'b0;
        if (tripped) begin
            case (act)
                ACT_HIZ:  begin d.lvl = 1'b0; d.hiz = 1'b1; end
                ACT_HIGH: d.lvl = 1'b1;
                ACT_LOW:  d.lvl = 1'b0;
                default:  d.lvl = pwm;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/trip_path.sv
module trip_path
    import trip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PH-1:0]   flt_raw_n,
    input  logic [N_PH-1:0]   flt_sync_n,
    input  logic [SEL_W-1:0]  sel,
    input  trip_cls_e         cls,
    input  logic              async_en,
    input  logic              glob,
    input  trip_act_e         act,
    input  logic              period_start,
    input  logic              clr,
    input  logic              pwm_in,
    output logic              pwm_out,
    output logic              hiz_out,
    output logic              ost_nxt,
    output logic              cbc_nxt,
    output logic              rise
);

    logic   ost_q, cbc_q;
    logic   ev_sync, ev_raw, force_now;
    drive_t drv;

    always_comb begin
        ev_sync = path_event(flt_sync_n, sel, glob);
        ev_raw  = path_event(flt_raw_n, sel, glob);
        // set wins over clear so a persisting fault keeps the latch
        ost_nxt = (ost_q & ~clr)          | (ev_sync & (cls == CLS_OST));
        cbc_nxt = (cbc_q & ~period_start) | (ev_sync & (cls == CLS_CBC));
        rise    = (ost_nxt & ~ost_q) | (cbc_nxt & ~cbc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ost_q <= 1'b0;
            cbc_q <= 1'b0;
        end else begin
            ost_q <= ost_nxt;
            cbc_q <= cbc_nxt;
        end
    end

    // asynchronous override straight from the raw comparator
    assign force_now = ost_q | cbc_q | (async_en & ev_raw);

    always_comb begin
        drv     = apply_act(act, pwm_in, force_now);
        pwm_out = drv.lvl;
        hiz_out = drv.hiz;
    end

    assert_ost_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ost_q && !clr) |=> ost_q);

    assert_cbc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cbc_q && !period_start) |=> cbc_q);

    assert_forced_low_R5: assert property (@(posedge clk) disable iff (rst)
        ((ost_q || cbc_q) && act == ACT_LOW) |-> (!pwm_out && !hiz_out));

endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
    import trip_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_PH-1:0]       flt_n,
    input  logic                  period_start,
    input  logic                  clr_trip,
    input  logic                  cfg_global,
    input  logic [N_PH*SEL_W-1:0] cfg_src_a,
    input  logic [N_PH*SEL_W-1:0] cfg_src_b,
    input  logic [N_PH-1:0]       cfg_cls_a,
    input  logic [N_PH-1:0]       cfg_cls_b,
    input  logic [N_PH-1:0]       cfg_async_a,
    input  logic [N_PH-1:0]       cfg_async_b,
    input  logic [N_PH*ACT_W-1:0] cfg_act_a,
    input  logic [N_PH*ACT_W-1:0] cfg_act_b,
    input  logic [N_PH-1:0]       pwm_a_in,
    input  logic [N_PH-1:0]       pwm_b_in,
    output logic [N_PH-1:0]       pwm_a_out,
    output logic [N_PH-1:0]       pwm_b_out,
    output logic [N_PH-1:0]       hiz_a,
    output logic [N_PH-1:0]       hiz_b,
    output logic [N_PH-1:0]       sts_ost,
    output logic [N_PH-1:0]       sts_cbc,
    output logic                  trip_irq
);

    logic [N_PH-1:0] flt_sync_n;
    logic [N_PH-1:0] ost_a, ost_b, cbc_a, cbc_b, rise_a, rise_b;

    trip_sync #(.WIDTH(N_PH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flt_n),
        .q   (flt_sync_n)
    );

    for (genvar c = 0; c < N_PH; c++) begin : g_ph
        trip_path u_path_a (
            .clk          (clk),
            .rst          (rst),
            .flt_raw_n    (flt_n),
            .flt_sync_n   (flt_sync_n),
            .sel          (cfg_src_a[c*SEL_W +: SEL_W]),
            .cls          (trip_cls_e'(cfg_cls_a[c])),
            .async_en     (cfg_async_a[c]),
            .glob         (cfg_global),
            .act          (trip_act_e'(cfg_act_a[c*ACT_W +: ACT_W])),
            .period_start (period_start),
            .clr          (clr_trip),
            .pwm_in       (pwm_a_in[c]),
            .pwm_out      (pwm_a_out[c]),
            .hiz_out      (hiz_a[c]),
            .ost_nxt      (ost_a[c]),
            .cbc_nxt      (cbc_a[c]),
            .rise         (rise_a[c])
        );
        trip_path u_path_b (
            .clk          (clk),
            .rst          (rst),
            .flt_raw_n    (flt_n),
            .flt_sync_n   (flt_sync_n),
            .sel          (cfg_src_b[c*SEL_W +: SEL_W]),
            .cls          (trip_cls_e'(cfg_cls_b[c])),
            .async_en     (cfg_async_b[c]),
            .glob         (cfg_global),
            .act          (trip_act_e'(cfg_act_b[c*ACT_W +: ACT_W])),
            .period_start (period_start),
            .clr          (clr_trip),
            .pwm_in       (pwm_b_in[c]),
            .pwm_out      (pwm_b_out[c]),
            .hiz_out      (hiz_b[c]),
            .ost_nxt      (ost_b[c]),
            .cbc_nxt      (cbc_b[c]),
            .rise         (rise_b[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_ost  <= '0;
            sts_cbc  <= '0;
            trip_irq <= 1'b0;
        end else begin
            sts_ost  <= (sts_ost & ~{N_PH{clr_trip}}) | ost_a | ost_b;
            sts_cbc  <= (sts_cbc & ~{N_PH{clr_trip}}) | cbc_a | cbc_b;
            trip_irq <= |(rise_a | rise_b);
        end
    end

    assert_irq_status_R9: assert property (@(posedge clk) disable iff (rst)
        trip_irq |-> (|(sts_ost | sts_cbc)));

    assert_sticky_ost_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_trip |=> ((sts_ost & $past(sts_ost)) == $past(sts_ost)));

    assert_sticky_cbc_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_trip |=> ((sts_cbc & $past(sts_cbc)) == $past(sts_cbc)));

endmodule

// File: tb/pwm_trip_ctrl_tb.sv
module pwm_trip_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] flt_n = 3'b111;
    logic       period_start = 1'b0;
    logic       clr_trip = 1'b0;
    logic       cfg_global = 1'b0;
    logic [5:0] cfg_src_a, cfg_src_b;
    logic [2:0] cfg_cls_a, cfg_cls_b, cfg_async_a, cfg_async_b;
    logic [5:0] cfg_act_a, cfg_act_b;
    logic [2:0] pwm_a_in = 3'b111, pwm_b_in = 3'b111;
    logic [2:0] pwm_a_out, pwm_b_out, hiz_a, hiz_b, sts_ost, sts_cbc;
    logic       trip_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] SRC_DEF = {2'd2, 2'd1, 2'd0};
    localparam logic [5:0] ACT_DEF = 6'b101010;

    always #4 clk = ~clk;

    pwm_trip_ctrl u_dut (
        .clk(clk), .rst(rst), .flt_n(flt_n), .period_start(period_start),
        .clr_trip(clr_trip), .cfg_global(cfg_global),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
        .cfg_cls_a(cfg_cls_a), .cfg_cls_b(cfg_cls_b),
        .cfg_async_a(cfg_async_a), .cfg_async_b(cfg_async_b),
        .cfg_act_a(cfg_act_a), .cfg_act_b(cfg_act_b),
        .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out),
        .hiz_a(hiz_a), .hiz_b(hiz_b),
        .sts_ost(sts_ost), .sts_cbc(sts_cbc), .trip_irq(trip_irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic defaults();
        cfg_global = 1'b0;
        cfg_src_a = SRC_DEF;  cfg_src_b = SRC_DEF;
        cfg_cls_a = 3'b000;   cfg_cls_b = 3'b000;
        cfg_async_a = 3'b000; cfg_async_b = 3'b000;
        cfg_act_a = ACT_DEF;  cfg_act_b = ACT_DEF;
        pwm_a_in = 3'b111;    pwm_b_in = 3'b111;
    endtask

    task automatic release_and_clear();
        flt_n = 3'b111;
        tick(3);
        clr_trip = 1'b1;
        tick(1);
        clr_trip = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset a_out", pwm_a_out, 3'b111);
        chk("R10 reset b_out", pwm_b_out, 3'b111);
        chk("R10 reset hiz", hiz_a | hiz_b, 3'b000);
        chk("R8 reset sts", sts_ost | sts_cbc, 3'b000);
        chk("R9 reset irq", {2'b00, trip_irq}, 3'b000);
    endtask

    task automatic t_oneshot();
        flt_n = 3'b110;
        tick(1);
        chk("R2 edge k", pwm_a_out, 3'b111);
        tick(1);
        chk("R2 edge k+1", pwm_a_out, 3'b111);
        tick(1);
        chk("R2 R11 edge k+2 a", pwm_a_out, 3'b110);
        chk("R1 edge k+2 b", pwm_b_out, 3'b110);
        chk("R9 irq raised", {2'b00, trip_irq}, 3'b001);
        chk("R8 sts_ost", sts_ost, 3'b001);
        tick(1);
        chk("R9 irq single", {2'b00, trip_irq}, 3'b000);
        flt_n = 3'b111;
        tick(3);
        chk("R3 hold after release", pwm_a_out, 3'b110);
        clr_trip = 1'b1; tick(1); clr_trip = 1'b0;
        chk("R3 clear", pwm_a_out, 3'b111);
        chk("R8 clear sts", sts_ost, 3'b000);
        flt_n = 3'b110;
        tick(3);
        clr_trip = 1'b1; tick(1); clr_trip = 1'b0;
        chk("R3 clear blocked by fault", pwm_a_out, 3'b110);
        chk("R8 set wins over clear", sts_ost, 3'b001);
        release_and_clear();
        chk("R3 clear after release", pwm_b_out, 3'b111);
    endtask

    task automatic t_select();
        cfg_src_a = {2'd2, 2'd1, 2'd2};
        flt_n = 3'b011;
        tick(3);
        chk("R1 cross select a", pwm_a_out, 3'b010);
        chk("R1 cross select b", pwm_b_out, 3'b011);
        release_and_clear();
        cfg_src_a = {2'd2, 2'd3, 2'd0};
        flt_n = 3'b101;
        tick(3);
        chk("R1 select none a", pwm_a_out, 3'b111);
        chk("R1 select V b", pwm_b_out, 3'b101);
        release_and_clear();
        cfg_src_a = SRC_DEF;
    endtask

    task automatic t_cbc();
        cfg_cls_a = 3'b111; cfg_cls_b = 3'b111;
        flt_n = 3'b110;
        tick(3);
        chk("R11 cbc tripped", pwm_a_out, 3'b110);
        chk("R8 sts_cbc", sts_cbc, 3'b001);
        chk("R11 no ost flag", sts_ost, 3'b000);
        period_start = 1'b1; tick(1); period_start = 1'b0;
        chk("R4 hold fault present", pwm_a_out, 3'b110);
        flt_n = 3'b111;
        tick(3);
        chk("R4 hold until period", pwm_b_out, 3'b110);
        period_start = 1'b1; tick(1); period_start = 1'b0;
        chk("R4 release at period", pwm_a_out, 3'b111);
        chk("R8 cbc sticky", sts_cbc, 3'b001);
        clr_trip = 1'b1; tick(1); clr_trip = 1'b0;
        chk("R8 cbc flag clear", sts_cbc, 3'b000);
        cfg_cls_a = 3'b000; cfg_cls_b = 3'b000;
    endtask

    task automatic t_actions();
        cfg_act_a = {2'b10, 2'b11, 2'b00};
        cfg_act_b = {2'b10, 2'b10, 2'b01};
        pwm_b_in = 3'b000;
        flt_n = 3'b100;
        tick(3);
        chk("R5 act a levels", pwm_a_out, 3'b110);
        chk("R5 act hiz a", hiz_a, 3'b001);
        chk("R5 act b levels", pwm_b_out, 3'b001);
        chk("R5 act hiz b", hiz_b, 3'b000);
        release_and_clear();
        chk("R10 untripped follow", pwm_b_out, 3'b000);
        cfg_act_a = ACT_DEF; cfg_act_b = ACT_DEF;
        pwm_b_in = 3'b111;
    endtask

    task automatic t_async();
        cfg_async_a = 3'b001;
        flt_n = 3'b110;
        #1;
        chk("R6 async force a", pwm_a_out, 3'b110);
        chk("R6 async leaves b", pwm_b_out, 3'b111);
        #1 flt_n = 3'b111;
        #1;
        chk("R6 async release", pwm_a_out, 3'b111);
        tick(3);
        chk("R6 glitch no latch", pwm_a_out, 3'b111);
        chk("R6 glitch no flag", sts_ost, 3'b000);
        cfg_async_a = 3'b000;
    endtask

    task automatic t_global();
        cfg_global = 1'b1;
        cfg_src_a[3:2] = 2'd3;
        flt_n = 3'b101;
        tick(3);
        chk("R7 global a", pwm_a_out, 3'b000);
        chk("R7 global b", pwm_b_out, 3'b000);
        chk("R7 global sts", sts_ost, 3'b111);
        chk("R9 global irq", {2'b00, trip_irq}, 3'b001);
        release_and_clear();
        chk("R7 global cleared", pwm_a_out & pwm_b_out, 3'b111);
        defaults();
    endtask

    initial begin
        defaults();
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_oneshot();
        t_select();
        t_cbc();
        t_actions();
        t_async();
        t_global();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule